// File: doc/BRIEF.md
# Feature-Gated Configuration Register

This block sits beside an interrupt router and holds its global configuration in two 32-bit registers. One of them is read-only and reports the features that the hardware supports. The other is a configuration/status word. The router takes two bits of that word: a global enable, and a mode bit that selects how core-id bytes in its routing tables are read. When the mode bit is set, the bytes are binary core numbers. When it is clear, they are one-hot masks.

Software reaches the two registers through a simple request/response port. Each request gets exactly one response one cycle later, and the response carries an okay or error status. The block enforces two rules:

- While the controller is enabled, the configuration is frozen. The only write it accepts then is a write of zero, which disables the controller.
- Any accepted value is masked by the feature register, so software can only set bits the hardware advertises.

A build parameter removes the register window. In that build the controller is enabled permanently and every access is refused.

Top module: `cfgreg_top`

## Requirements
- R1: While reset is asserted and after it, until the first accepted write, the status register reads zero and both `ctrl_enable` and `ctrl_encode` are low. This applies when the window is present.
- R2: A write to the feature register at byte offset 0x0 gets an error response and changes no state.
- R3: A nonzero write to the configuration register at byte offset 0x4 while the enable bit (bit 0) is set gets an error response, and the register keeps its value.
- R4: An accepted configuration write stores the written value ANDed with the feature register and gets an okay response.
- R5: A write of zero to the configuration register is accepted even while the controller is enabled, and it clears the register.
- R6: Reading the feature register returns the feature parameter with the extension bit (bit 2) also set, with an okay response.
- R7: Reading the configuration register returns its current value with an okay response.
- R8: An access to any other offset gets an error response with zero data and changes no state.
- R9: Without the window, every access gets an error response with zero data, `ctrl_enable` is 1 and `ctrl_encode` is 0, including during reset.
- R10: `ctrl_enable` follows status bit 0. `ctrl_encode` follows status bit 1, where 1 means binary core ids and 0 means one-hot core ids.
- R11: Every request gets exactly one response, in the cycle after it. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | 1 when the access was refused |
| rsp_rdata | output | 32 | Read data; zero on an error or a write |
| ctrl_enable | output | 1 | Global enable to the router |
| ctrl_encode | output | 1 | Core-id mode to the router: 1 binary, 0 one-hot |

## Verification
The configuration register is written in three situations: while disabled, while enabled with a nonzero value, and while enabled with zero. These separate the lock rule from the zero-write exception.

All-ones and sparse write values show whether the feature mask is applied. Writes aimed at the feature register and at unmapped offsets are each followed by a read-back, which shows that refused accesses leave nothing behind.

A second instance without the window runs on the same stimulus and must refuse everything while holding enable high. Back-to-back requests confirm the one-cycle, one-for-one response timing.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
   localparam int REG_W = 32;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_FEAT = 2'd1,
      ACC_CFG  = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/cfgreg_decode.sv
module cfgreg_decode
   import cfgreg_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int FEAT_OFS = 0,
   parameter int CFG_OFS  = 4,
   parameter bit VIRT_EXT = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind
);
   localparam logic [ADDR_W-1:0] FEAT_A = ADDR_W'(FEAT_OFS);
   localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_OFS);

   generate
      if (VIRT_EXT) begin : g_window
         always_comb begin
            if (addr == FEAT_A)      kind = ACC_FEAT;
            else if (addr == CFG_A)  kind = ACC_CFG;
            else                     kind = ACC_NONE;
         end
      end else begin : g_nowindow
         logic unused_addr;
         assign unused_addr = ^addr;
         assign kind = ACC_NONE;
      end
   endgenerate
endmodule

// File: rtl/cfgreg_state.sv
module cfgreg_state
   import cfgreg_pkg::*;
#(
   parameter logic [REG_W-1:0] FEAT_REG = 32'h7,
   parameter int               EN_BIT   = 0,
   parameter bit               VIRT_EXT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_cfg,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] status,
   output logic             wr_reject
);
   generate
      if (VIRT_EXT) begin : g_reg
         logic locked;
         assign locked    = status[EN_BIT];
         assign wr_reject = wr_cfg && locked && (wdata != '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       status <= '0;
            else if (wr_cfg && !wr_reject)    status <= wdata & FEAT_REG;
         end

         // R3
         locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_cfg && status[EN_BIT] && (wdata != '0)) |=> $stable(status));
         // R4
         feat_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_cfg && !status[EN_BIT]) |=> ((status & ~FEAT_REG) == '0));
         // R5
         zero_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_cfg && (wdata == '0)) |=> (status == '0));
         // R2
         idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_cfg |=> $stable(status));
      end else begin : g_fixed
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ wr_cfg ^ (^wdata);
         assign status    = REG_W'(1) << EN_BIT;
         assign wr_reject = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/cfgreg_resp.sv
module cfgreg_resp
   import cfgreg_pkg::*;
#(
   parameter logic [REG_W-1:0] FEAT_REG = 32'h7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  acc_kind_e        kind,
   input  logic [REG_W-1:0] status,
   input  logic             wr_reject,
   output logic             rsp_valid,
   output logic             rsp_err,
   output logic [REG_W-1:0] rsp_rdata
);
   logic             nxt_err;
   logic [REG_W-1:0] nxt_data;

   always_comb begin
      nxt_err  = 1'b0;
      nxt_data = '0;
      unique case (kind)
         ACC_FEAT: begin
            if (req_write) nxt_err  = 1'b1;
            else           nxt_data = FEAT_REG;
         end
         ACC_CFG: begin
            if (req_write) nxt_err  = wr_reject;
            else           nxt_data = status;
         end
         default: nxt_err = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && nxt_err;
         rsp_rdata <= req_valid ? nxt_data : '0;
      end
   end

   // R2
   feat_wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && kind == ACC_FEAT) |=> rsp_err);
   // R11
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R11
   rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R8
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == '0));
endmodule

// File: rtl/cfgreg_top.sv
module cfgreg_top
   import cfgreg_pkg::*;
#(
   parameter int               ADDR_W       = 4,
   parameter int               FEAT_OFS     = 0,
   parameter int               CFG_OFS      = 4,
   parameter logic [REG_W-1:0] FEAT_VALUE   = 32'h3,
   parameter int               EN_BIT       = 0,
   parameter int               ENC_BIT      = 1,
   parameter int               EXT_FEAT_BIT = 2,
   parameter bit               VIRT_EXT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [REG_W-1:0]  req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [REG_W-1:0]  rsp_rdata,
   output logic              ctrl_enable,
   output logic              ctrl_encode
);
   localparam logic [REG_W-1:0] EXT_MASK = REG_W'(1) << EXT_FEAT_BIT;
   localparam logic [REG_W-1:0] FEAT_REG = VIRT_EXT ? (FEAT_VALUE | EXT_MASK) : FEAT_VALUE;

   generate
      if (EN_BIT == ENC_BIT) begin : g_bad_bits
         $error("enable and encode bits must differ");
      end
      if (EN_BIT >= REG_W || ENC_BIT >= REG_W || EXT_FEAT_BIT >= REG_W) begin : g_bad_range
         $error("bit position outside the register");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("address too narrow for two word registers");
      end
      if (FEAT_OFS == CFG_OFS) begin : g_bad_ofs
         $error("register offsets collide");
      end
   endgenerate

   acc_kind_e        kind;
   logic [REG_W-1:0] status;
   logic             wr_reject;
   logic             wr_cfg;

   assign wr_cfg = req_valid && req_write && (kind == ACC_CFG);

   cfgreg_decode #(
      .ADDR_W(ADDR_W), .FEAT_OFS(FEAT_OFS), .CFG_OFS(CFG_OFS), .VIRT_EXT(VIRT_EXT)
   ) u_decode (
      .addr(req_addr),
      .kind(kind)
   );

   cfgreg_state #(
      .FEAT_REG(FEAT_REG), .EN_BIT(EN_BIT), .VIRT_EXT(VIRT_EXT)
   ) u_state (
      .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wdata(req_wdata),
      .status(status), .wr_reject(wr_reject)
   );

   cfgreg_resp #(
      .FEAT_REG(FEAT_REG)
   ) u_resp (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .kind(kind), .status(status), .wr_reject(wr_reject),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   assign ctrl_enable = status[EN_BIT];
   assign ctrl_encode = status[ENC_BIT];

   generate
      if (!VIRT_EXT) begin : g_nx_chk
         // R9
         forced_en_chk: assert property (@(posedge clk) ctrl_enable && !ctrl_encode);
      end
   endgenerate
endmodule

// File: tb/tb_cfgreg_top.sv
module tb_cfgreg_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err, ctrl_enable, ctrl_encode;
   logic [31:0] rsp_rdata;
   logic        nx_valid, nx_err, nx_enable, nx_encode;
   logic [31:0] nx_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [32:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgreg_top dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ctrl_enable(ctrl_enable),
      .ctrl_encode(ctrl_encode)
   );

   cfgreg_top #(.VIRT_EXT(1'b0)) dut_nx (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(nx_valid),
      .rsp_err(nx_err), .rsp_rdata(nx_rdata), .ctrl_enable(nx_enable),
      .ctrl_encode(nx_encode)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // Monitor: pops the scoreboard whenever a response shows up
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check("R11 unexpected response", 32'h1, 32'h0);
         end else begin
            logic [32:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " err"}, {31'h0, rsp_err}, {31'h0, e[32]});
            check({t, " data"}, rsp_rdata, e[31:0]);
         end
         // R9: the windowless build refuses everything
         check("R9 nx err", {31'h0, nx_err}, 32'h1);
         check("R9 nx data", nx_rdata, 32'h0);
      end
      if (rst_n) check("R11 nx timing", {31'h0, nx_valid}, {31'h0, rsp_valid});
   end

   task automatic drive(input logic wr, input logic [3:0] a, input logic [31:0] d,
                        input logic e_err, input logic [31:0] e_data, input string tag);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      exp_q.push_back({e_err, e_data});
      tag_q.push_back(tag);
   endtask

   task automatic access(input logic wr, input logic [3:0] a, input logic [31:0] d,
                         input logic e_err, input logic [31:0] e_data, input string tag);
      @(negedge clk);
      drive(wr, a, d, e_err, e_data, tag);
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      checks++;
      $display("FAIL watchdog actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
      check("R1 enable in reset", {31'h0, ctrl_enable}, 32'h0);
      check("R1 encode in reset", {31'h0, ctrl_encode}, 32'h0);
      check("R9 enable in reset", {31'h0, nx_enable}, 32'h1);
      check("R9 encode in reset", {31'h0, nx_encode}, 32'h0);
      rst_n = 1'b1;

      access(1'b0, 4'h0, 32'h0, 1'b0, 32'h7, "R6 feature read");
      access(1'b0, 4'h4, 32'h0, 1'b0, 32'h0, "R1 status after reset");

      access(1'b1, 4'h0, 32'hFFFF_FFFF, 1'b1, 32'h0, "R2 feature write");
      access(1'b0, 4'h0, 32'h0, 1'b0, 32'h7, "R2 feature kept");
      access(1'b0, 4'h4, 32'h0, 1'b0, 32'h0, "R2 status kept");
      @(negedge clk);
      check("R2 enable untouched", {31'h0, ctrl_enable}, 32'h0);

      access(1'b1, 4'h4, 32'hFFFF_FFFA, 1'b0, 32'h0, "R4 masked write");
      access(1'b0, 4'h4, 32'h0, 1'b0, 32'h2, "R4 masked value");
      check("R10 encode set", {31'h0, ctrl_encode}, 32'h1);
      check("R10 enable clear", {31'h0, ctrl_enable}, 32'h0);

      access(1'b1, 4'h4, 32'h3, 1'b0, 32'h0, "R4 enable write");
      access(1'b0, 4'h4, 32'h0, 1'b0, 32'h3, "R7 status read");
      check("R10 enable set", {31'h0, ctrl_enable}, 32'h1);

      access(1'b1, 4'h4, 32'h2, 1'b1, 32'h0, "R3 locked write");
      access(1'b0, 4'h4, 32'h0, 1'b0, 32'h3, "R3 value kept");
      access(1'b1, 4'h4, 32'h8, 1'b1, 32'h0, "R3 locked unadvertised write");
      access(1'b1, 4'h0, 32'h0, 1'b1, 32'h0, "R2 feature write while enabled");

      access(1'b1, 4'h8, 32'hFFFF_FFFF, 1'b1, 32'h0, "R8 stray write");
      access(1'b0, 4'h8, 32'h0, 1'b1, 32'h0, "R8 stray read");
      access(1'b0, 4'hC, 32'h0, 1'b1, 32'h0, "R8 stray read high");
      access(1'b0, 4'h4, 32'h0, 1'b0, 32'h3, "R8 status kept");

      access(1'b1, 4'h4, 32'h0, 1'b0, 32'h0, "R5 zero write while enabled");
      access(1'b0, 4'h4, 32'h0, 1'b0, 32'h0, "R5 cleared");
      check("R5 enable dropped", {31'h0, ctrl_enable}, 32'h0);
      check("R10 encode dropped", {31'h0, ctrl_encode}, 32'h0);

      access(1'b1, 4'h4, 32'h0000_0105, 1'b0, 32'h0, "R4 sparse write");
      access(1'b0, 4'h4, 32'h0, 1'b0, 32'h5, "R4 sparse masked");
      check("R10 enable after sparse", {31'h0, ctrl_enable}, 32'h1);
      check("R10 encode after sparse", {31'h0, ctrl_encode}, 32'h0);

      // R11: back-to-back requests
      @(negedge clk);
      drive(1'b0, 4'h0, 32'h0, 1'b0, 32'h7, "R11 burst first");
      @(negedge clk);
      drive(1'b0, 4'h4, 32'h0, 1'b0, 32'h5, "R11 burst second");
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check("R11 all responses seen", exp_q.size(), 32'h0);

      rst_n = 1'b0;
      @(negedge clk);
      check("R1 enable on reset", {31'h0, ctrl_enable}, 32'h0);
      check("R9 enable on reset", {31'h0, nx_enable}, 32'h1);
      rst_n = 1'b1;
      access(1'b0, 4'h4, 32'h0, 1'b0, 32'h0, "R1 status after second reset");
      @(negedge clk);
      check("R11 queue drained", exp_q.size(), 32'h0);
      finish_run();
   end
endmodule